// File: doc/BRIEF.md
# Four-Lane Float Dot-Product Unit

This unit takes two 128-bit operand vectors, each packed with four IEEE-754 binary32 values. It forms the four lane products and sums them into one scalar. The scalar is then copied into all four lanes of a 128-bit result. The arithmetic is not fused. Every product and every partial sum is rounded as a separate operation, and the adds always run in the same left-to-right order. The result therefore matches a scalar program that computes a four-element dot product step by step.

A single multiplier and a single adder are shared across the steps, so one operation takes several clock cycles. The caller presents both operands and the flush mode, then pulses `start` while the unit is idle. A one-cycle `done` pulse marks the cycle in which the broadcast result is valid. When flush mode is on, subnormal values are replaced by zeros of the same sign. This applies to the inputs, the products and the sums.

Top module: `fpdot4_unit`

## Requirements
- R1: Lane i occupies bits [32i+31:32i] of each vector. Lane i of `a_vec` is multiplied by lane i of `b_vec` for i = 0..3, and the scalar result is the sum of the four products.
- R2: The sum is computed as ((p0 + p1) + p2) + p3. Each product and each add rounds separately to nearest, ties to even, so for example 2^24 + 1 + 1 + 0 yields exactly 2^24 (0x4B800000).
- R3: With `flush_en` = 1, a product that would be subnormal becomes a zero carrying the product's sign. With `flush_en` = 0, the subnormal product is kept.
- R4: With `flush_en` = 1, a subnormal sum becomes a signed zero. With `flush_en` = 0, a subnormal sum is delivered unchanged.
- R5: With `flush_en` = 1, subnormal operand lanes are treated as zeros of the same sign. With `flush_en` = 0, they take part in the arithmetic with their full value.
- R6: A NaN operand, an infinity multiplied by zero, or the sum of two infinities of opposite sign gives the quiet NaN 0x7FC00000.
- R7: A result too large for binary32 gives an infinity of the correct sign (0x7F800000 or 0xFF800000).
- R8: All four lanes of `result` carry the same 32-bit scalar.
- R9: `done` is high for exactly one cycle. It rises 7 clock cycles after the edge that accepted `start` (4 multiply steps and 3 add steps), and `result` is valid in that cycle.
- R10: While an operation is in progress, `start` and new operand values are ignored. No extra `done` is produced, and the result of the operation already running is not changed.
- R11: During synchronous reset, `done` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| flush_en | input | 1 | 1 = replace subnormals by signed zeros |
| a_vec | input | 128 | Four binary32 lanes of operand A |
| b_vec | input | 128 | Four binary32 lanes of operand B |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 128 | Scalar dot product copied to all four lanes |

## Verification
Some properties are checked on every cycle by the assertions. These are the single-cycle `done` pulse and its exact distance from the accepting edge. The assertions also check that operands stay frozen while the unit is busy. With flush on, they check that no stored product and no delivered sum is subnormal. Any NaN result must be the default quiet NaN. The numeric content needs the bench scenarios with hand-derived bit patterns. That content covers lane pairing, non-associative rounding with ties to even, and signed zeros from flushing. It also covers subnormals that survive when flush is off, overflow to signed infinity, and each NaN source. The bench also shows that a `start` arriving mid-operation leaves both the result and the pulse count unchanged.

// File: rtl/fpdot_pkg.sv
package fpdot_pkg;
  localparam int FW = 32;
  typedef logic [FW-1:0] f32_t;
  localparam f32_t QNAN = 32'h7FC00000;

  function automatic logic is_nan(input f32_t v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic logic is_inf(input f32_t v);
    return (v[30:23] == 8'hFF) && (v[22:0] == 23'd0);
  endfunction

  function automatic logic is_sub(input f32_t v);
    return (v[30:23] == 8'h00) && (v[22:0] != 23'd0);
  endfunction

  // zero test honouring the flush mode (subnormal counts as zero when flushing)
  function automatic logic is_zero(input f32_t v, input logic flush);
    return (v[30:0] == 31'd0) || (flush && v[30:23] == 8'h00);
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_ADD} phase_t;
endpackage

// File: rtl/fpdot_round.sv
// Rounds a normalised significand (hidden, 23 fraction, guard, sticky)
// to nearest-even, handles gradual underflow, overflow and optional flush.
module fpdot_round
  import fpdot_pkg::*;
(
  input  logic               flush,
  input  logic               sign,
  input  logic signed [10:0] bexp,
  input  logic [25:0]        sig,
  output f32_t               y
);
  logic signed [10:0] sh;
  logic [25:0] msk, shv, s2;
  logic [7:0]  ef;
  logic        inc;
  f32_t        w;

  always_comb begin
    sh  = 11'sd1 - bexp;
    msk = '0;
    shv = '0;
    s2  = sig;
    ef  = bexp[7:0];
    if (bexp < 11'sd1) begin
      ef = 8'd0;
      if (sh >= 11'sd26) begin
        s2 = {25'd0, |sig};
      end else begin
        msk = (26'd1 << sh[4:0]) - 26'd1;
        shv = sig >> sh[4:0];
        s2  = {shv[25:1], shv[0] | (|(sig & msk))};
      end
    end
    inc = s2[1] & (s2[0] | s2[2]);
    w   = {sign, ef, s2[24:2]} + {31'd0, inc};
    if (bexp >= 11'sd255)
      y = {sign, 8'hFF, 23'd0};
    else if (flush && w[30:23] == 8'h00 && w[22:0] != 23'd0)
      y = {sign, 31'd0};
    else
      y = w;
  end
endmodule

// File: rtl/fpdot_mul.sv
module fpdot_mul
  import fpdot_pkg::*;
(
  input  logic flush,
  input  f32_t a,
  input  f32_t b,
  output f32_t y
);
  localparam int PW = 48;

  logic        az, bz, sgn, bad;
  logic [23:0] ma, mb;
  logic [7:0]  ea, eb;
  logic [PW-1:0] prod, pn;
  logic [5:0]  lz;
  logic signed [10:0] ex;
  f32_t        rnd;

  always_comb begin
    az   = is_zero(a, flush);
    bz   = is_zero(b, flush);
    sgn  = a[31] ^ b[31];
    bad  = is_nan(a) || is_nan(b) || (is_inf(a) && bz) || (is_inf(b) && az);
    ma   = {a[30:23] != 8'h00, a[22:0]};
    mb   = {b[30:23] != 8'h00, b[22:0]};
    ea   = (a[30:23] == 8'h00) ? 8'd1 : a[30:23];
    eb   = (b[30:23] == 8'h00) ? 8'd1 : b[30:23];
    prod = PW'(ma) * PW'(mb);
    lz   = '0;
    for (int i = 0; i < PW; i++)
      if (prod[i]) lz = 6'(PW - 1 - i);
    pn   = prod << lz;
    ex   = $signed({3'b000, ea}) + $signed({3'b000, eb}) - 11'sd126 - $signed({5'b00000, lz});
  end

  fpdot_round u_rnd (
    .flush (flush),
    .sign  (sgn),
    .bexp  (ex),
    .sig   ({pn[47:23], |pn[22:0]}),
    .y     (rnd)
  );

  always_comb begin
    if (bad)                    y = QNAN;
    else if (is_inf(a) || is_inf(b)) y = {sgn, 8'hFF, 23'd0};
    else if (az || bz)          y = {sgn, 31'd0};
    else                        y = rnd;
  end
endmodule

// File: rtl/fpdot_add.sv
module fpdot_add
  import fpdot_pkg::*;
(
  input  logic flush,
  input  f32_t a,
  input  f32_t b,
  output f32_t y
);
  localparam int GW = 27;  // 24 significand bits + guard, round, sticky

  logic        az, bz, bad, swp;
  f32_t        x, s;
  logic [23:0] mx, ms;
  logic [7:0]  ex, es, d;
  logic [GW-1:0] big, sm0, sml, shv;
  logic [GW:0] sum, sn;
  logic [4:0]  lz;
  logic signed [10:0] be;
  f32_t        rnd;

  always_comb begin
    az  = is_zero(a, flush);
    bz  = is_zero(b, flush);
    bad = is_nan(a) || is_nan(b) || (is_inf(a) && is_inf(b) && (a[31] != b[31]));
    swp = b[30:0] > a[30:0];
    x   = swp ? b : a;
    s   = swp ? a : b;
    mx  = {x[30:23] != 8'h00, x[22:0]};
    ms  = {s[30:23] != 8'h00, s[22:0]};
    ex  = (x[30:23] == 8'h00) ? 8'd1 : x[30:23];
    es  = (s[30:23] == 8'h00) ? 8'd1 : s[30:23];
    d   = ex - es;
    big = {mx, 3'b000};
    sm0 = {ms, 3'b000};
    shv = '0;
    if (d >= 8'd27) begin
      sml = {26'd0, |sm0};
    end else begin
      shv = sm0 >> d;
      sml = {shv[GW-1:1], shv[0] | (|(sm0 & ((27'd1 << d) - 27'd1)))};
    end
    if (x[31] == s[31]) sum = {1'b0, big} + {1'b0, sml};
    else                sum = {1'b0, big} - {1'b0, sml};
    lz = '0;
    for (int i = 0; i <= GW; i++)
      if (sum[i]) lz = 5'(GW - i);
    sn = sum << lz;
    be = $signed({3'b000, ex}) + 11'sd1 - $signed({6'd0, lz});
  end

  fpdot_round u_rnd (
    .flush (flush),
    .sign  (x[31]),
    .bexp  (be),
    .sig   ({sn[27:3], |sn[2:0]}),
    .y     (rnd)
  );

  always_comb begin
    if (bad)               y = QNAN;
    else if (is_inf(a))    y = a;
    else if (is_inf(b))    y = b;
    else if (az && bz)     y = {a[31] & b[31], 31'd0};
    else if (az)           y = b;
    else if (bz)           y = a;
    else if (sum == '0)    y = 32'd0;
    else                   y = rnd;
  end
endmodule

// File: rtl/fpdot4_unit.sv
module fpdot4_unit
  import fpdot_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                flush_en,
  input  logic [LANES*32-1:0] a_vec,
  input  logic [LANES*32-1:0] b_vec,
  output logic                done,
  output logic [LANES*32-1:0] result
);
  localparam int VW  = LANES * FW;
  localparam int CW  = $clog2(LANES);
  localparam int LAT = 2 * LANES - 1;

  phase_t        state_q;
  logic [CW-1:0] cnt_q, nxt_idx;
  logic [VW-1:0] a_q, b_q;
  logic          flush_q;
  f32_t          prod_q [LANES];
  f32_t          acc_q, mul_y, add_x, add_y, add_r;

  assign nxt_idx = cnt_q + 1'b1;
  assign add_x   = (cnt_q == '0) ? prod_q[0] : acc_q;
  assign add_y   = prod_q[nxt_idx];

  fpdot_mul u_mul (
    .flush (flush_q),
    .a     (a_q[cnt_q*FW +: FW]),
    .b     (b_q[cnt_q*FW +: FW]),
    .y     (mul_y)
  );

  fpdot_add u_add (
    .flush (flush_q),
    .a     (add_x),
    .b     (add_y),
    .y     (add_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      flush_q <= 1'b0;
      acc_q   <= '0;
      done    <= 1'b0;
      result  <= '0;
      for (int i = 0; i < LANES; i++) prod_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          a_q     <= a_vec;
          b_q     <= b_vec;
          flush_q <= flush_en;
          cnt_q   <= '0;
          state_q <= ST_MUL;
        end
        ST_MUL: begin
          prod_q[cnt_q] <= mul_y;
          if (cnt_q == CW'(LANES - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_ADD;
          end else begin
            cnt_q <= nxt_idx;
          end
        end
        ST_ADD: begin
          acc_q <= add_r;
          if (cnt_q == CW'(LANES - 2)) begin
            result  <= {LANES{add_r}};
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= nxt_idx;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // cycles since the accepting edge, for the latency check
  logic [7:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                            since_q <= '0;
    else if (state_q == ST_IDLE && start) since_q <= '0;
    else if (state_q != ST_IDLE)        since_q <= since_q + 8'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> since_q == 8'(LAT)); // R9
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(a_q) && $stable(b_q) && $stable(flush_q)); // R10
  AST_NAN_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (done && is_nan(result[FW-1:0])) |-> result[FW-1:0] == QNAN); // R6
  AST_SUM_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    (done && flush_q) |-> !is_sub(result[FW-1:0])); // R4

  for (genvar g = 0; g < LANES; g++) begin : g_pchk
    AST_PROD_FLUSHED: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ADD && flush_q) |-> !is_sub(prod_q[g])); // R3
  end
endmodule

// File: tb/fpdot4_unit_tb.sv
module fpdot4_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         flush_en = 1'b0;
  logic [127:0] a_vec = '0;
  logic [127:0] b_vec = '0;
  logic         done;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ndone  = 0;

  typedef struct {
    logic [127:0] res;
    int           t0;
    string        tag;
  } exp_t;
  exp_t sb[$];

  fpdot4_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .flush_en(flush_en),
    .a_vec(a_vec), .b_vec(b_vec), .done(done), .result(result)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] v4(input logic [31:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      ndone++;
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected done", result, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result === e.res, e.tag, result, e.res);
        check(cyc == e.t0 + 8, "R9 latency", 128'(cyc - e.t0), 128'd8);
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  task automatic run(input logic [127:0] a, input logic [127:0] b, input logic fl,
                     input logic [31:0] s, input string tag);
    exp_t e;
    @(negedge clk);
    a_vec = a; b_vec = b; flush_en = fl; start = 1'b1;
    e.res = {4{s}}; e.t0 = cyc; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000, THR = 32'h40400000,
                          FOUR = 32'h40800000, HALF = 32'h3F000000, MONE = 32'hBF800000,
                          PINF = 32'h7F800000, NINF = 32'hFF800000, NZ = 32'h80000000;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R11 done in reset", {127'd0, done}, '0);
    check(result == '0, "R11 result in reset", result, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R8: 1+2+3+4 = 10.0 in every lane
    run(v4(ONE, TWO, THR, FOUR), v4(ONE, ONE, ONE, ONE), 1'b0, 32'h41200000, "R1 R8 basic");
    // R1: 4 - 3 + 2 + 2 = 5.0
    run(v4(TWO, THR, FOUR, HALF), v4(TWO, MONE, HALF, FOUR), 1'b0, 32'h40A00000, "R1 mixed signs");
    // R2: 2^24 + 1 + 1 rounds to 2^24 at each add
    run(v4(32'h4B800000, ONE, ONE, 0), v4(ONE, ONE, ONE, ONE), 1'b0, 32'h4B800000, "R2 ordered rounding");
    // R2: 2^24 + 3 is a tie between 2^24+2 and 2^24+4, even gives +4
    run(v4(32'h4B800000, THR, 0, 0), v4(ONE, ONE, 0, 0), 1'b0, 32'h4B800002, "R2 ties to even");
    // R6 NaN sources
    run(v4(32'h7F800001, 0, 0, 0), v4(ONE, 0, 0, 0), 1'b0, 32'h7FC00000, "R6 NaN operand");
    run(v4(PINF, 0, 0, 0), v4(0, 0, 0, 0), 1'b0, 32'h7FC00000, "R6 inf times zero");
    run(v4(PINF, NINF, 0, 0), v4(ONE, ONE, 0, 0), 1'b0, 32'h7FC00000, "R6 inf minus inf");
    // R7 overflow
    run(v4(32'h7F000000, 0, 0, 0), v4(FOUR, 0, 0, 0), 1'b0, PINF, "R7 positive overflow");
    run(v4(32'h7F000000, 0, 0, 0), v4(32'hC0800000, 0, 0, 0), 1'b1, NINF, "R7 negative overflow");
    // R3 subnormal product 2^-140
    run(v4(32'h0D800000, 0, 0, 0), v4(32'h2B800000, 0, 0, 0), 1'b1, 32'h00000000, "R3 product flushed");
    run(v4(32'h8D800000, NZ, NZ, NZ), v4(32'h2B800000, ONE, ONE, ONE), 1'b1, NZ, "R3 flushed keeps sign");
    run(v4(32'h0D800000, 0, 0, 0), v4(32'h2B800000, 0, 0, 0), 1'b0, 32'h00000200, "R3 R4 product kept");
    run(v4(32'h8D800000, NZ, NZ, NZ), v4(32'h2B800000, ONE, ONE, ONE), 1'b0, 32'h80000200, "R4 negative subnormal kept");
    // R5 subnormal operand
    run(v4(32'h00000001, 0, 0, 0), v4(32'h71800000, 0, 0, 0), 1'b1, 32'h00000000, "R5 operand flushed");
    run(v4(32'h00000001, 0, 0, 0), v4(32'h71800000, 0, 0, 0), 1'b0, 32'h27000000, "R5 operand used");
    // R4 subnormal sum: 1.5*2^-126 - 2^-126
    run(v4(32'h00C00000, 32'h80800000, 0, 0), v4(ONE, ONE, 0, 0), 1'b1, 32'h00000000, "R4 sum flushed");
    run(v4(32'h00C00000, 32'h80800000, 0, 0), v4(ONE, ONE, 0, 0), 1'b0, 32'h00400000, "R4 sum kept");

    // R10: second start during the operation is ignored
    begin
      exp_t e;
      int base;
      base = ndone;
      @(negedge clk);
      a_vec = v4(ONE, TWO, THR, FOUR); b_vec = v4(ONE, ONE, ONE, ONE); flush_en = 1'b0; start = 1'b1;
      e.res = {4{32'h41200000}}; e.t0 = cyc; e.tag = "R10 busy start ignored";
      sb.push_back(e);
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      a_vec = v4(FOUR, FOUR, FOUR, FOUR); flush_en = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
      repeat (12) @(negedge clk);
      check(ndone == base + 1, "R10 single done", 128'(ndone - base), 128'd1);
    end

    check(sb.size() == 0, "R9 all results delivered", 128'(sb.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule